// File: doc/BRIEF.md
# Global Hold/Toggle Duty-Cycle Controller

This block sits between the per-stage toggle control register of a low-power pattern generator and its hold stages. It switches the whole generator between two alternating periods. In the toggle period each stage enable passes through unchanged. In the hold period every stage enable is forced low, so all hold stages keep their stored value and the scan chains they feed see no transitions. The block does this whatever the control register holds.

The length of each period is counted in shift cycles and is set by a small programmable register. A toggle flip-flop records which period is active. It flips on a single-cycle pulse that a down-counter raises when the active period runs out. The counter and the flip-flop stand still whenever shifting is paused, and during capture.

Writes land in working registers. Shadow copies feed the timer, so the settings cannot move while a pattern is in flight. At the start of each pattern, the shadows take the working values and the timer restarts from the beginning of a period.

Top module: `duty_hold_ctrl`

## Requirements
- R1: After reset the controller is in the toggle period (`in_hold`=0) with durations toggle=3 and hold=2 (defaults). The first 3 counted shift cycles are toggle, the next 2 are hold, and the pattern repeats.
- R2: While `in_hold`=1 every bit of `stage_en_out` is 0. While `in_hold`=0, `stage_en_out` equals `stage_en_in` in the same cycle.
- R3: With toggle duration T>0 and hold duration H>0, counting from a pattern start, the counted shift cycles form the sequence T toggle cycles followed by H hold cycles, repeating. A cycle counts when `shift_en`=1 and `capture`=0.
- R4: A cycle with `shift_en`=0 is not counted and does not change `in_hold`.
- R5: A hold duration of 0 disables the global hold: `in_hold` stays 0 for the whole pattern.
- R6: A toggle duration of 0 together with a nonzero hold duration gives permanent hold: `in_hold`=1 from the pattern start onward.
- R7: `wr_en`=1 writes `wr_data` into the working hold duration when `wr_sel`=0, or into the working toggle duration when `wr_sel`=1. A written value has no effect until the next pattern start. A pattern start is the first cycle with `capture`=0 after a cycle with `capture`=1. At a pattern start the shadows take the working values and the period restarts: toggle, or hold under R6.
- R8: While `capture`=1 the period state does not advance and `in_hold` is unchanged, even when `shift_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | High on scan shift cycles; paces the duration counter |
| capture | input | 1 | High during capture; its falling edge marks a pattern start |
| wr_en | input | 1 | Write strobe for a working duration register |
| wr_sel | input | 1 | 0 selects the hold duration, 1 the toggle duration |
| wr_data | input | DUR_W | Duration value to write |
| stage_en_in | input | STAGES | Per-stage enables from the toggle control register |
| stage_en_out | output | STAGES | Enables after the global hold gating |
| in_hold | output | 1 | 1 during the global hold period |

## Verification
Some properties are checked on every cycle by the assertions:
- no stage enable leaks through while the hold period is active;
- the counter and the period flip-flop stay still on cycles that are not counted;
- the counter steps down by exactly one on counted cycles;
- the two degenerate duration settings pin the period indicator;
- the shadows do not move during capture.

Other behaviour can only be shown by the bench's scenarios. These are the exact toggle/hold run lengths for every pair of durations from 0 to 15, the restart alignment at each pattern start, and the deferral of a mid-pattern write until the next start.

// File: rtl/duty_hold_pkg.sv
`timescale 1ns/1ps
// Shared types for the hold/toggle duty-cycle controller.
// Assumes: a single bit is enough to encode the period and the register select.
package duty_hold_pkg;

    typedef enum logic {
        PH_TOGGLE = 1'b0,
        PH_HOLD   = 1'b1
    } phase_e;

    typedef enum logic {
        SEL_HOLD   = 1'b0,
        SEL_TOGGLE = 1'b1
    } dur_sel_e;

endpackage

// File: rtl/duty_regs.sv
`timescale 1ns/1ps
// Working and shadow duration registers, plus pattern-start detection.
// What it does: software writes land in the working copies. The shadow copies
// load only on a pattern start, the first cycle with capture low after
// capture was high.
// Assumes: capture is synchronous to clk.
module duty_regs #(
    parameter int unsigned DUR_W    = 4,
    parameter int unsigned HOLD_RST = 2,
    parameter int unsigned TOG_RST  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [DUR_W-1:0] wr_data_i,
    output logic             pat_start_o,
    output logic [DUR_W-1:0] wk_hold_o,
    output logic [DUR_W-1:0] wk_tog_o,
    output logic [DUR_W-1:0] sh_hold_o,
    output logic [DUR_W-1:0] sh_tog_o
);
    import duty_hold_pkg::*;

    localparam logic [DUR_W-1:0] HOLD_INIT = DUR_W'(HOLD_RST);
    localparam logic [DUR_W-1:0] TOG_INIT  = DUR_W'(TOG_RST);

    logic capture_q;

    // Remember last cycle's capture level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) capture_q <= 1'b0;
        else        capture_q <= capture_i;
    end

    assign pat_start_o = capture_q & ~capture_i;

    // Working registers: take a write from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_hold_o <= HOLD_INIT;
            wk_tog_o  <= TOG_INIT;
        end else if (wr_en_i) begin
            if (dur_sel_e'(wr_sel_i) == SEL_TOGGLE) wk_tog_o  <= wr_data_i;
            else                                    wk_hold_o <= wr_data_i;
        end
    end

    // Shadow registers: copy the working values only at a pattern start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hold_o <= HOLD_INIT;
            sh_tog_o  <= TOG_INIT;
        end else if (pat_start_o) begin
            sh_hold_o <= wk_hold_o;
            sh_tog_o  <= wk_tog_o;
        end
    end

    // R7: the shadows cannot change while capture is in progress.
    assert_shadow_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> ($stable(sh_hold_o) && $stable(sh_tog_o)));

endmodule

// File: rtl/duty_timer.sv
`timescale 1ns/1ps
// Period timer: a down-counter and the period T flip-flop.
// What it does: the counter holds the shift cycles left in the active period.
// When the period runs out, a one-cycle pulse flips the T flip-flop and the
// counter reloads with the other period's duration. A zero duration either
// turns off the hold period or pins the generator in hold.
// Assumes: adv_i is high only on counted shift cycles. restart_i comes with
// the next shadow values on nx_*_i.
module duty_timer #(
    parameter int unsigned DUR_W    = 4,
    parameter int unsigned HOLD_RST = 2,
    parameter int unsigned TOG_RST  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv_i,
    input  logic                  restart_i,
    input  logic [DUR_W-1:0]      sh_hold_i,
    input  logic [DUR_W-1:0]      sh_tog_i,
    input  logic [DUR_W-1:0]      nx_hold_i,
    input  logic [DUR_W-1:0]      nx_tog_i,
    output duty_hold_pkg::phase_e phase_o
);
    import duty_hold_pkg::*;

    localparam logic [DUR_W-1:0] HOLD_INIT = DUR_W'(HOLD_RST);
    localparam logic [DUR_W-1:0] TOG_INIT  = DUR_W'(TOG_RST);
    localparam logic [DUR_W-1:0] ONE       = DUR_W'(1);

    phase_e           phase_q;
    logic [DUR_W-1:0] cnt_q;
    logic             hold_off;
    logic             hold_lock;
    logic             t_pulse;
    logic [DUR_W-1:0] next_dur;

    // Period a restart begins in: hold only when toggle is 0 and hold is not.
    function automatic phase_e start_phase(input logic [DUR_W-1:0] h,
                                           input logic [DUR_W-1:0] t);
        return ((t == '0) && (h != '0)) ? PH_HOLD : PH_TOGGLE;
    endfunction

    // Duration loaded when a restart enters its starting period.
    function automatic logic [DUR_W-1:0] start_dur(input logic [DUR_W-1:0] h,
                                                   input logic [DUR_W-1:0] t);
        return (start_phase(h, t) == PH_HOLD) ? h : t;
    endfunction

    // Decode the degenerate duration settings held in the shadows.
    always_comb begin
        hold_off  = (sh_hold_i == '0);
        hold_lock = (sh_tog_i == '0) && !hold_off;
    end

    // Pulse to the T flip-flop: one cycle when the active period is spent.
    always_comb begin
        t_pulse = 1'b0;
        if (adv_i) begin
            if (hold_off)       t_pulse = (phase_q == PH_HOLD);
            else if (hold_lock) t_pulse = (phase_q == PH_TOGGLE);
            else                t_pulse = (cnt_q <= ONE);
        end
    end

    // Duration of the period that is entered after a flip.
    assign next_dur = (phase_q == PH_HOLD) ? sh_tog_i : sh_hold_i;

    // T flip-flop: keeps the active period and flips on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= start_phase(HOLD_INIT, TOG_INIT);
        else if (restart_i) phase_q <= start_phase(nx_hold_i, nx_tog_i);
        else if (t_pulse)   phase_q <= (phase_q == PH_HOLD) ? PH_TOGGLE : PH_HOLD;
    end

    // Down-counter: reloads on entering a period, else steps down on each counted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= start_dur(HOLD_INIT, TOG_INIT);
        else if (restart_i)              cnt_q <= start_dur(nx_hold_i, nx_tog_i);
        else if (t_pulse)                cnt_q <= next_dur;
        else if (adv_i && cnt_q > ONE)   cnt_q <= cnt_q - ONE;
    end

    assign phase_o = phase_q;

    // R4: with no counted cycle and no restart, the timer state stays put.
    assert_frozen_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !restart_i) |=> ($stable(phase_q) && $stable(cnt_q)));

    // R3: in normal alternation a counted cycle before expiry takes exactly one off the count.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !restart_i && !hold_off && !hold_lock && cnt_q > ONE)
        |=> (cnt_q == $past(cnt_q) - ONE) && (phase_q == $past(phase_q)));

    // R3: a pulse in normal alternation always changes the period.
    assert_pulse_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_pulse && !restart_i) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/duty_stage_gate.sv
`timescale 1ns/1ps
// Stage-enable gating: one AND gate per hold stage.
// What it does: while the global hold is active, every stage enable is forced low.
// Assumes: hold_i comes straight from a register, so no glitch reaches the stages.
module duty_stage_gate #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic [STAGES-1:0] en_i,
    output logic [STAGES-1:0] en_o
);
    // One AND gate per stage, masking the enable with "not in hold".
    for (genvar g = 0; g < STAGES; g++) begin : g_and
        assign en_o[g] = en_i[g] & ~hold_i;
    end

    // R2: nothing leaks through during the hold period.
    assert_hold_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> (en_o == '0));

endmodule

// File: rtl/duty_hold_ctrl.sv
`timescale 1ns/1ps
// Top of the global hold/toggle duty-cycle controller.
// What it does: runs the generator through alternating toggle and hold
// periods of programmable length, counted in shift cycles. During hold it
// masks every per-stage enable.
// Assumes: shift_en and capture are synchronous. Capture cycles are not counted.
module duty_hold_ctrl #(
    parameter int unsigned STAGES   = 8,
    parameter int unsigned DUR_W    = 4,
    parameter int unsigned HOLD_RST = 2,
    parameter int unsigned TOG_RST  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              capture,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DUR_W-1:0]  wr_data,
    input  logic [STAGES-1:0] stage_en_in,
    output logic [STAGES-1:0] stage_en_out,
    output logic              in_hold
);
    import duty_hold_pkg::*;

    logic             pat_start;
    logic             adv;
    logic [DUR_W-1:0] wk_hold;
    logic [DUR_W-1:0] wk_tog;
    logic [DUR_W-1:0] sh_hold;
    logic [DUR_W-1:0] sh_tog;
    phase_e           phase;

    // A cycle counts only when shifting and not capturing.
    assign adv = shift_en & ~capture;

    duty_regs #(.DUR_W(DUR_W), .HOLD_RST(HOLD_RST), .TOG_RST(TOG_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (capture),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .pat_start_o (pat_start),
        .wk_hold_o   (wk_hold),
        .wk_tog_o    (wk_tog),
        .sh_hold_o   (sh_hold),
        .sh_tog_o    (sh_tog)
    );

    duty_timer #(.DUR_W(DUR_W), .HOLD_RST(HOLD_RST), .TOG_RST(TOG_RST)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .restart_i (pat_start),
        .sh_hold_i (sh_hold),
        .sh_tog_i  (sh_tog),
        .nx_hold_i (wk_hold),
        .nx_tog_i  (wk_tog),
        .phase_o   (phase)
    );

    assign in_hold = (phase == PH_HOLD);

    duty_stage_gate #(.STAGES(STAGES)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .hold_i(in_hold),
        .en_i  (stage_en_in),
        .en_o  (stage_en_out)
    );

    // R5: a zero hold duration never lets the hold period appear.
    assert_no_hold_when_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_hold == '0) |-> !in_hold);

    // R6: a zero toggle duration with nonzero hold pins the generator in hold.
    assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sh_tog == '0) && (sh_hold != '0)) |-> in_hold);

    // R8: capture freezes the period, even if shift_en is high.
    assert_capture_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !pat_start) |=> $stable(in_hold));

endmodule

// File: tb/duty_hold_ctrl_bench.sv
`timescale 1ns/1ps
// Sweep bench: every pair of toggle and hold durations from 0 to 15. Expected
// period values come from the position in counted shift cycles.
module duty_hold_ctrl_bench;
    localparam int STAGES = 8;
    localparam int DUR_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              shift_en = 1'b0;
    logic              capture = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [DUR_W-1:0]  wr_data = '0;
    logic [STAGES-1:0] stage_en_in = '0;
    logic [STAGES-1:0] stage_en_out;
    logic              in_hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    duty_hold_ctrl #(.STAGES(STAGES), .DUR_W(DUR_W)) u_duty_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture(capture),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .stage_en_in(stage_en_in), .stage_en_out(stage_en_out), .in_hold(in_hold)
    );

    // Expected period value after p counted shift cycles since the pattern start.
    function automatic logic exp_hold(input int t, input int h, input int p);
        if (h == 0) return 1'b0;
        if (t == 0) return 1'b1;
        return (p % (t + h)) >= t;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs after the falling edge, then settle before sampling.
    task automatic cyc(input logic se, input logic cap, input logic we, input logic ws,
                       input logic [DUR_W-1:0] wd, input logic [STAGES-1:0] sin);
        @(negedge clk);
        shift_en = se; capture = cap; wr_en = we; wr_sel = ws; wr_data = wd;
        stage_en_in = sin;
        #5;
    endtask

    task automatic chk_gate(input logic hold_exp);
        chk("R2", stage_en_out, hold_exp ? '0 : stage_en_in);
    endtask

    initial begin
        logic prev;
        int p;
        // Reset
        cyc(0, 0, 0, 0, '0, '0);
        cyc(0, 0, 0, 0, '0, '0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, '0, 8'hA5);
        chk("R1 reset in_hold", in_hold, 0);
        chk("R1 reset gate", stage_en_out, 8'hA5);
        // R1: default durations toggle=3, hold=2
        p = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1, 0, 0, 0, '0, 8'(i * 29 + 3));
            chk("R1", in_hold, exp_hold(3, 2, p));
            chk_gate(exp_hold(3, 2, p));
            p++;
        end
        // Full sweep of durations
        for (int t = 0; t < 16; t++) begin
            for (int h = 0; h < 16; h++) begin
                cyc(0, 0, 1, 0, 4'(h), '1);   // R7 working hold duration
                cyc(0, 0, 1, 1, 4'(t), '1);   // R7 working toggle duration
                prev = in_hold;
                cyc(1, 1, 0, 0, '0, '1);      // capture, shift_en high: R8
                chk("R8", in_hold, prev);
                cyc(1, 1, 0, 0, '0, '1);
                chk("R8", in_hold, prev);
                cyc(0, 0, 0, 0, '0, '1);      // pattern start
                p = 0;
                for (int i = 0; i < 36; i++) begin
                    logic se;
                    logic we;
                    logic e;
                    se = (i % 7) != 6;
                    we = (i == 18) || (i == 19);
                    cyc(se, 0, we, i == 19, 4'(t + h + 5), 8'(i * 37 + t * 5 + h));
                    e = exp_hold(t, h, p);
                    if (!se)        chk("R4", in_hold, e);
                    else if (i > 18) chk("R7 deferred write", in_hold, e);
                    else if (h == 0) chk("R5", in_hold, e);
                    else if (t == 0) chk("R6", in_hold, e);
                    else             chk("R3", in_hold, e);
                    chk_gate(e);
                    if (se) p++;
                end
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule